// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block runs whole transactions against one addressed device on an I2C bus: a presence probe, a write of 1 to 256 data bytes behind an optional internal address, and a random read that first sets the device's internal pointer and then reads 1 to 256 bytes. It does not move the bus wires itself. It issues one command at a time (START, STOP, byte write, byte read) to a bit-level engine and acts on the acknowledge result that the engine returns with each completion.

A transaction is launched by a one-cycle `go` with the device address, an internal address of 0 to 4 bytes, a length code and option bits. Write data is pulled one byte at a time through a ready/valid pair. Read data is pushed out one byte per `rd_valid` pulse. At the end, `done`, an error code and a count of data bytes that were not acknowledged are held until the next launch. Before the read phase, the block can place a repeated START or a STOP followed by START. It can also fold the address bits that lie beyond the chosen address length into the low device-address bits, for memories that spread their address across the device-address field.

States: IDLE waits for `go`. START issues the opening START. DEV_WR sends the device byte with R/W=0. ADDR sends internal address bytes. FETCH waits for a write byte. DATA sends it. MID_STOP issues the STOP of a split read. RESTART issues the START that opens the read phase. DEV_RD sends the device byte with R/W=1. RD_BYTE reads bytes. STOP closes the transaction. Transitions: IDLE→START on `go`. START→DEV_RD for a read with no address, otherwise START→DEV_WR. DEV_WR→STOP on a NACK or for a probe. DEV_WR→ADDR when the address length is non-zero, otherwise DEV_WR→FETCH. ADDR→STOP on a NACK. ADDR stays in ADDR for the remaining bytes, then goes to FETCH (write), RESTART (read, repeated START) or MID_STOP (read, split). MID_STOP→RESTART. RESTART→DEV_RD. FETCH→DATA on `wr_valid`. DATA→FETCH while bytes remain, otherwise DATA→STOP. DEV_RD→RD_BYTE. RD_BYTE loops until the last byte, then goes to STOP. STOP→IDLE.

Top module: `i2cmem_seq`

## Requirements
- R1: A probe (`xfer_mode`=0, or 3) issues START, WRITE of {device, 0}, STOP. `err_code` is 1 (no device) if that byte was NACKed, otherwise 0.
- R2: In a write (`xfer_mode`=1), a NACK on the device byte is followed at once by STOP and `err_code`=1. No address or data byte is sent.
- R3: Internal address bytes (`addr_len` 0..4, any larger value treated as 4) are sent most significant byte first, taken from the low `addr_len` bytes of `mem_addr`. A NACK on any of them is followed at once by STOP and `err_code`=2.
- R4: A NACK on a write data byte does not end the write. `fail_cnt` equals the number of NACKed data bytes when `done` rises.
- R5: A read (`xfer_mode`=2) with `addr_len`>0 first sends START, {device,0} and the address bytes. Then `rep_start`=1 gives START alone, and `rep_start`=0 gives STOP then START.
- R6: A read with `addr_len`=0 sends {device,1} right after the opening START.
- R7: The read phase sends WRITE of {device,1} and then `len_m1`+1 READ commands. `cmd_nack_out`=1 on the last one only, and STOP follows. Each received byte appears on `rd_data` with a one-cycle `rd_valid`.
- R8: With `fold_en`=1, the device address used is `dev_addr` OR (bits of `mem_addr` from bit 8·`addr_len` upward, masked by `fold_mask`).
- R9: A write requests exactly `len_m1`+1 bytes (1..256), each by holding `wr_ready` until `wr_valid`, and sends them in order.
- R10: `go` has no effect while `busy` is high.
- R11: `done`, `err_code` and `fail_cnt` hold their values until the next accepted `go`, which clears `done`.
- R12: Command encoding is 0 START, 1 STOP, 2 WRITE, 3 READ. `cmd_valid`, `cmd_op`, `cmd_wdata` and `cmd_nack_out` stay stable until `eng_done`, and each `eng_done` completes exactly one command.
- R13: After reset the block is idle: `busy`, `done`, `cmd_valid`, `wr_ready`, `rd_valid` are 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Launch a transaction when idle |
| xfer_mode | input | 2 | 0/3 probe, 1 write, 2 read |
| dev_addr | input | 7 | Device address |
| mem_addr | input | 32 | Internal address |
| addr_len | input | 3 | Internal address bytes, 0..4 |
| len_m1 | input | 8 | Data byte count minus one |
| rep_start | input | 1 | Read phase opens with repeated START |
| fold_en | input | 1 | Enable folding of high address bits |
| fold_mask | input | 7 | Device bits that folded address may set |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Sequencer wants a write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Transaction running |
| done | output | 1 | Transaction finished, held |
| err_code | output | 2 | 0 none, 1 no device, 2 address NACK |
| fail_cnt | output | 9 | NACKed data bytes of the last write |
| cmd_valid | output | 1 | Command to bit engine pending |
| cmd_op | output | 2 | Command code |
| cmd_wdata | output | 8 | Byte for WRITE |
| cmd_nack_out | output | 1 | Acknowledge bit to send after READ (1 = NACK) |
| eng_done | input | 1 | Bit engine finished the pending command |
| eng_nack | input | 1 | NACK seen on a WRITE |
| eng_rdata | input | 8 | Byte received by a READ |

## Verification
On every cycle, the assertions check that a pending command holds still until the engine completes it. They also check that a NACK on the device or address byte is followed directly by STOP, that the NACKed last read is followed by STOP, that `go` during a run leaves the block busy, and that results hold while idle. What only the scenarios can show is the content of a whole command stream: address byte order, the two read-turnaround forms, address folding, the count of failed data bytes and the order of read bytes. The bench builds the expected stream independently from each stimulus row and compares it with the log its engine model records.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        XF_PROBE = 2'd0,
        XF_WRITE = 2'd1,
        XF_READ  = 2'd2
    } xfer_t;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_NODEV = 2'd1;
    localparam logic [1:0] ERR_ADDR  = 2'd2;

endpackage

// File: rtl/i2cmem_dev_fold.sv
module i2cmem_dev_fold #(
    parameter int ADDR_BYTES = 4,
    parameter int DEV_W      = 7
) (
    input  logic [DEV_W-1:0]                 dev_in,
    input  logic [ADDR_BYTES*8-1:0]          addr_in,
    input  logic [$clog2(ADDR_BYTES+1)-1:0]  alen,
    input  logic                             en,
    input  logic [DEV_W-1:0]                 mask,
    output logic [DEV_W-1:0]                 dev_out
);
    localparam int AW    = ADDR_BYTES * 8;
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);

    logic [DEV_W-1:0] cand [ADDR_BYTES+1];
    logic [DEV_W-1:0] sel;

    // bits of the address that lie above each possible address length
    for (genvar k = 0; k <= ADDR_BYTES; k++) begin : g_cand
        if (k == ADDR_BYTES) begin : g_none
            assign cand[k] = '0;
        end else begin : g_part
            localparam int HI = (k * 8 + DEV_W - 1 < AW - 1) ? k * 8 + DEV_W - 1 : AW - 1;
            assign cand[k] = DEV_W'(addr_in[HI:k*8]);
        end
    end

    always_comb begin
        sel = '0;
        for (int j = 0; j <= ADDR_BYTES; j++) begin
            if (alen == IDX_W'(j)) sel = cand[j];
        end
        dev_out = en ? (dev_in | (sel & mask)) : dev_in;
    end
endmodule

// File: rtl/i2cmem_byte_pick.sv
module i2cmem_byte_pick #(
    parameter int ADDR_BYTES = 4
) (
    input  logic [ADDR_BYTES*8-1:0]          addr_in,
    input  logic [$clog2(ADDR_BYTES+1)-1:0]  idx,
    output logic [7:0]                       byte_out
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);

    logic [7:0] lane [ADDR_BYTES];

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
        assign lane[k] = addr_in[k*8 +: 8];
    end

    always_comb begin
        byte_out = '0;
        for (int j = 0; j < ADDR_BYTES; j++) begin
            if (idx == IDX_W'(j)) byte_out = lane[j];
        end
    end
endmodule

// File: rtl/i2cmem_seq.sv
module i2cmem_seq
    import i2cmem_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                go,
    input  logic [1:0]                          xfer_mode,
    input  logic [6:0]                          dev_addr,
    input  logic [ADDR_BYTES*8-1:0]             mem_addr,
    input  logic [$clog2(ADDR_BYTES+1)-1:0]     addr_len,
    input  logic [LEN_W-1:0]                    len_m1,
    input  logic                                rep_start,
    input  logic                                fold_en,
    input  logic [6:0]                          fold_mask,
    input  logic                                wr_valid,
    input  logic [7:0]                          wr_data,
    output logic                                wr_ready,
    output logic                                rd_valid,
    output logic [7:0]                          rd_data,
    output logic                                busy,
    output logic                                done,
    output logic [1:0]                          err_code,
    output logic [LEN_W:0]                      fail_cnt,
    output logic                                cmd_valid,
    output logic [1:0]                          cmd_op,
    output logic [7:0]                          cmd_wdata,
    output logic                                cmd_nack_out,
    input  logic                                eng_done,
    input  logic                                eng_nack,
    input  logic [7:0]                          eng_rdata
);
    localparam int DEV_W = 7;
    localparam int AW    = ADDR_BYTES * 8;
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);
    localparam int CNT_W = LEN_W + 1;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEV_WR, S_ADDR, S_FETCH, S_DATA,
        S_MID_STOP, S_RESTART, S_DEV_RD, S_RD_BYTE, S_STOP
    } state_t;

    state_t            state_q, state_d;
    xfer_t             mode_q;
    logic [DEV_W-1:0]  dev_q, dev_eff;
    logic [AW-1:0]     addr_q;
    logic [IDX_W-1:0]  alen_q, idx_q, alen_c;
    logic [LEN_W-1:0]  cnt_q;
    logic              rs_q;
    logic [7:0]        wbuf_q, addr_byte;
    logic [1:0]        err_q;
    logic [CNT_W-1:0]  fail_q;
    logic              done_q, rdv_q;
    logic [7:0]        rdd_q;

    assign alen_c = (addr_len > IDX_W'(ADDR_BYTES)) ? IDX_W'(ADDR_BYTES) : addr_len;

    i2cmem_dev_fold #(.ADDR_BYTES(ADDR_BYTES), .DEV_W(DEV_W)) u_fold (
        .dev_in (dev_addr),
        .addr_in(mem_addr),
        .alen   (alen_c),
        .en     (fold_en),
        .mask   (fold_mask),
        .dev_out(dev_eff)
    );

    i2cmem_byte_pick #(.ADDR_BYTES(ADDR_BYTES)) u_pick (
        .addr_in (addr_q),
        .idx     (idx_q),
        .byte_out(addr_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (go) state_d = S_START;
            S_START:    if (eng_done)
                            state_d = (mode_q == XF_READ && alen_q == '0) ? S_DEV_RD : S_DEV_WR;
            S_DEV_WR:   if (eng_done) begin
                            if (eng_nack || mode_q == XF_PROBE) state_d = S_STOP;
                            else if (alen_q != '0)              state_d = S_ADDR;
                            else                                state_d = S_FETCH;
                        end
            S_ADDR:     if (eng_done) begin
                            if (eng_nack)                 state_d = S_STOP;
                            else if (idx_q == '0) begin
                                if (mode_q == XF_WRITE)   state_d = S_FETCH;
                                else if (rs_q)            state_d = S_RESTART;
                                else                      state_d = S_MID_STOP;
                            end
                        end
            S_FETCH:    if (wr_valid) state_d = S_DATA;
            S_DATA:     if (eng_done) state_d = (cnt_q == '0) ? S_STOP : S_FETCH;
            S_MID_STOP: if (eng_done) state_d = S_RESTART;
            S_RESTART:  if (eng_done) state_d = S_DEV_RD;
            S_DEV_RD:   if (eng_done) state_d = S_RD_BYTE;
            S_RD_BYTE:  if (eng_done && cnt_q == '0) state_d = S_STOP;
            S_STOP:     if (eng_done) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // command and handshake outputs
    always_comb begin
        cmd_valid    = 1'b0;
        cmd_op       = OP_START;
        cmd_wdata    = '0;
        cmd_nack_out = 1'b0;
        wr_ready     = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_START,
            S_RESTART:  cmd_valid = 1'b1;
            S_STOP,
            S_MID_STOP: begin cmd_valid = 1'b1; cmd_op = OP_STOP; end
            S_DEV_WR:   begin cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_wdata = {dev_q, 1'b0}; end
            S_DEV_RD:   begin cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_wdata = {dev_q, 1'b1}; end
            S_ADDR:     begin cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_wdata = addr_byte; end
            S_DATA:     begin cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_wdata = wbuf_q; end
            S_FETCH:    wr_ready = 1'b1;
            S_RD_BYTE:  begin cmd_valid = 1'b1; cmd_op = OP_READ; cmd_nack_out = (cnt_q == '0); end
            default:    ;
        endcase
    end

    // transaction registers and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= XF_PROBE;
            dev_q  <= '0;
            addr_q <= '0;
            alen_q <= '0;
            idx_q  <= '0;
            cnt_q  <= '0;
            rs_q   <= 1'b0;
            wbuf_q <= '0;
            err_q  <= ERR_NONE;
            fail_q <= '0;
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            rdd_q  <= '0;
        end else begin
            rdv_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (go) begin
                    mode_q <= (xfer_mode == 2'd1) ? XF_WRITE :
                              (xfer_mode == 2'd2) ? XF_READ  : XF_PROBE;
                    dev_q  <= dev_eff;
                    addr_q <= mem_addr;
                    alen_q <= alen_c;
                    idx_q  <= alen_c - 1'b1;
                    cnt_q  <= len_m1;
                    rs_q   <= rep_start;
                    err_q  <= ERR_NONE;
                    fail_q <= '0;
                    done_q <= 1'b0;
                end
                S_DEV_WR: if (eng_done && eng_nack) err_q <= ERR_NODEV;
                S_ADDR: if (eng_done) begin
                    if (eng_nack)           err_q <= ERR_ADDR;
                    else if (idx_q != '0)   idx_q <= idx_q - 1'b1;
                end
                S_FETCH: if (wr_valid) wbuf_q <= wr_data;
                S_DATA: if (eng_done) begin
                    if (eng_nack)      fail_q <= fail_q + 1'b1;
                    if (cnt_q != '0)   cnt_q  <= cnt_q - 1'b1;
                end
                S_RD_BYTE: if (eng_done) begin
                    rdv_q <= 1'b1;
                    rdd_q <= eng_rdata;
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end
                S_STOP: if (eng_done) done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign err_code = err_q;
    assign fail_cnt = fail_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;

    // R12: a pending command does not move until the engine completes it
    a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !eng_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_nack_out));

    // R2 and R3: a NACKed device or address byte is followed straight by STOP
    a_r3_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEV_WR || state_q == S_ADDR) && eng_done && eng_nack && mode_q != XF_PROBE
        |=> cmd_valid && cmd_op == OP_STOP);

    // R7: the NACKed final read is followed by STOP
    a_r7_last_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == OP_READ && cmd_nack_out && eng_done |=> cmd_valid && cmd_op == OP_STOP);

    // R10: go during a run does not disturb it
    a_r10_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && go && !(state_q == S_STOP && eng_done) |=> busy && !done);

    // R11: results hold while idle and no go arrives
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !go |=> $stable(done) && $stable(err_code) && $stable(fail_cnt));

endmodule

// File: tb/i2cmem_seq_test.sv
module i2cmem_seq_test;
    localparam int LOGN = 300;

    typedef struct packed {
        logic [1:0]  mode;
        logic [6:0]  dev;
        logic [31:0] addr;
        logic [2:0]  alen;
        logic [7:0]  lenm1;
        logic        rs;
        logic        ovf;
        logic [6:0]  mask;
        logic [15:0] nm;
    } vec_t;

    localparam vec_t VECS [13] = '{
        {2'd0, 7'h50, 32'h0000_0000, 3'd0, 8'd0,   1'b0, 1'b0, 7'h00, 16'h0000},
        {2'd0, 7'h50, 32'h0000_0000, 3'd0, 8'd0,   1'b0, 1'b0, 7'h00, 16'h0001},
        {2'd1, 7'h50, 32'h0000_1234, 3'd2, 8'd2,   1'b0, 1'b0, 7'h00, 16'h0000},
        {2'd1, 7'h50, 32'h0000_1234, 3'd2, 8'd2,   1'b0, 1'b0, 7'h00, 16'h0028},
        {2'd1, 7'h50, 32'h0000_1234, 3'd2, 8'd2,   1'b0, 1'b0, 7'h00, 16'h0001},
        {2'd1, 7'h50, 32'h0000_1234, 3'd2, 8'd2,   1'b0, 1'b0, 7'h00, 16'h0004},
        {2'd2, 7'h50, 32'h0000_0007, 3'd1, 8'd3,   1'b1, 1'b0, 7'h00, 16'h0000},
        {2'd2, 7'h50, 32'h0000_1234, 3'd2, 8'd0,   1'b0, 1'b0, 7'h00, 16'h0000},
        {2'd2, 7'h50, 32'h0000_0000, 3'd0, 8'd1,   1'b0, 1'b0, 7'h00, 16'h0000},
        {2'd1, 7'h50, 32'h0000_0305, 3'd1, 8'd0,   1'b0, 1'b1, 7'h07, 16'h0000},
        {2'd2, 7'h50, 32'hDEAD_BEEF, 3'd4, 8'd255, 1'b1, 1'b1, 7'h7F, 16'h0000},
        {2'd1, 7'h50, 32'h00AB_CDEF, 3'd3, 8'd0,   1'b0, 1'b0, 7'h00, 16'h0000},
        {2'd1, 7'h50, 32'h0102_0304, 3'd7, 8'd0,   1'b0, 1'b0, 7'h00, 16'h0000}
    };
    string ROW_TAG [13] = '{"R1", "R1", "R9", "R4", "R2", "R3", "R5", "R5", "R6", "R8", "R7", "R3", "R3"};

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic [1:0] xfer_mode = '0;
    logic [6:0] dev_addr = '0, fold_mask = '0;
    logic [31:0] mem_addr = '0;
    logic [2:0] addr_len = '0;
    logic [7:0] len_m1 = '0, wr_data, rd_data, cmd_wdata, eng_rdata;
    logic rep_start = 1'b0, fold_en = 1'b0, wr_valid, wr_ready, rd_valid, busy, done;
    logic [1:0] err_code, cmd_op;
    logic [8:0] fail_cnt;
    logic cmd_valid, cmd_nack_out, eng_done, eng_nack;

    i2cmem_seq uut (
        .clk(clk), .rst_n(rst_n), .go(go), .xfer_mode(xfer_mode), .dev_addr(dev_addr),
        .mem_addr(mem_addr), .addr_len(addr_len), .len_m1(len_m1), .rep_start(rep_start),
        .fold_en(fold_en), .fold_mask(fold_mask), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .err_code(err_code), .fail_cnt(fail_cnt), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .cmd_nack_out(cmd_nack_out), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_rdata(eng_rdata)
    );

    always #2 clk = ~clk;

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    logic [10:0] log_q [LOGN];
    logic [7:0]  rdcap [LOGN];
    int log_n = 0, rd_n = 0, wcount = 0, rcount = 0, widx = 0, dly = 0;
    logic [15:0] nm_cur = '0;

    logic [10:0] exp_log [LOGN];
    int exp_n, exp_err, exp_fail, exp_rd;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // bit-engine and data-source model: acts on falling edges only
    initial begin
        eng_done = 1'b0; eng_nack = 1'b0; eng_rdata = '0; wr_valid = 1'b0; wr_data = '0;
        forever begin
            @(negedge clk);
            if (rd_valid && rd_n < LOGN) begin rdcap[rd_n] = rd_data; rd_n++; end
            if (eng_done) begin
                eng_done = 1'b0; dly = 0;
            end else if (cmd_valid) begin
                dly++;
                if (dly >= 2) begin
                    if (log_n < LOGN) begin
                        log_q[log_n] = {cmd_op, (cmd_op == 2'd3) ? cmd_nack_out : 1'b0,
                                        (cmd_op == 2'd2) ? cmd_wdata : 8'h00};
                        log_n++;
                    end
                    eng_nack = 1'b0;
                    if (cmd_op == 2'd2) begin
                        if (wcount < 16) eng_nack = nm_cur[wcount];
                        wcount++;
                    end
                    if (cmd_op == 2'd3) begin
                        eng_rdata = 8'h3C + 8'(7 * rcount);
                        rcount++;
                    end
                    eng_done = 1'b1;
                end
            end
            if (wr_valid && !wr_ready) begin
                wr_valid = 1'b0; widx++;
            end else if (wr_ready && !wr_valid) begin
                wr_valid = 1'b1; wr_data = 8'hC0 + 8'(widx);
            end
        end
    end

    task automatic push(input logic [1:0] op, input logic nk, input logic [7:0] d);
        exp_log[exp_n] = {op, nk, d};
        exp_n++;
    endtask

    // expected command stream built from the requirements
    task automatic build_expect(input vec_t v);
        int a, w;
        logic [63:0] up;
        logic [6:0] dv;
        exp_n = 0; exp_err = 0; exp_fail = 0; exp_rd = 0; w = 0;
        a = (v.alen > 3'd4) ? 4 : int'(v.alen);
        up = 64'(v.addr) >> (8 * a);
        dv = v.ovf ? (v.dev | (7'(up) & v.mask)) : v.dev;
        push(2'd0, 1'b0, 8'h00);
        if (!(v.mode == 2'd2 && a == 0)) begin
            push(2'd2, 1'b0, {dv, 1'b0});
            if (v.nm[w]) begin push(2'd1, 1'b0, 8'h00); exp_err = 1; return; end
            w++;
            if (v.mode != 2'd1 && v.mode != 2'd2) begin push(2'd1, 1'b0, 8'h00); return; end
            for (int i = a - 1; i >= 0; i--) begin
                push(2'd2, 1'b0, v.addr[i*8 +: 8]);
                if (v.nm[w]) begin push(2'd1, 1'b0, 8'h00); exp_err = 2; return; end
                w++;
            end
            if (v.mode == 2'd1) begin
                for (int j = 0; j <= int'(v.lenm1); j++) begin
                    push(2'd2, 1'b0, 8'hC0 + 8'(j));
                    if (w < 16 && v.nm[w]) exp_fail++;
                    w++;
                end
                push(2'd1, 1'b0, 8'h00);
                return;
            end
            if (!v.rs) push(2'd1, 1'b0, 8'h00);
            push(2'd0, 1'b0, 8'h00);
        end
        push(2'd2, 1'b0, {dv, 1'b1});
        for (int j = 0; j <= int'(v.lenm1); j++) push(2'd3, (j == int'(v.lenm1)), 8'h00);
        push(2'd1, 1'b0, 8'h00);
        exp_rd = int'(v.lenm1) + 1;
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        xfer_mode = v.mode; dev_addr = v.dev; mem_addr = v.addr; addr_len = v.alen;
        len_m1 = v.lenm1; rep_start = v.rs; fold_en = v.ovf; fold_mask = v.mask;
        nm_cur = v.nm; log_n = 0; rd_n = 0; wcount = 0; rcount = 0; widx = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic compare_run(input vec_t v, input string tag);
        int bad;
        build_expect(v);
        chk(log_n == exp_n, "R12", {tag, " command count"}, log_n, exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (bad < 0 && log_q[i] !== exp_log[i]) bad = i;
        chk(bad < 0, tag, "command stream", (bad < 0) ? 0 : int'(log_q[bad]),
            (bad < 0) ? 0 : int'(exp_log[bad]));
        chk(int'(err_code) == exp_err, tag, "err_code", int'(err_code), exp_err);
        chk(int'(fail_cnt) == exp_fail, "R4", {tag, " fail_cnt"}, int'(fail_cnt), exp_fail);
        if (v.mode == 2'd2) begin
            bad = -1;
            for (int i = 0; i < rd_n; i++)
                if (bad < 0 && rdcap[i] !== 8'h3C + 8'(7 * i)) bad = i;
            chk(rd_n == exp_rd && bad < 0, "R7", {tag, " read bytes"}, rd_n, exp_rd);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !done && !cmd_valid && !wr_ready && !rd_valid && err_code == 2'd0,
            "R13", "reset state", {busy, done, cmd_valid, wr_ready, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !cmd_valid, "R13", "idle after release", {busy, cmd_valid}, 0);

        for (int r = 0; r < 13; r++) begin
            launch(VECS[r]);
            wait_done();
            compare_run(VECS[r], ROW_TAG[r]);
        end

        // R10: a second go in mid-run with different inputs is ignored
        launch(VECS[2]);
        repeat (6) @(negedge clk);
        xfer_mode = 2'd2; dev_addr = 7'h11; addr_len = 3'd0; len_m1 = 8'd5;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        wait_done();
        compare_run(VECS[2], "R10");

        // R11: results hold while idle, then clear on the next launch
        launch(VECS[3]);
        wait_done();
        xfer_mode = 2'd0; fold_en = 1'b1; mem_addr = 32'hFFFF_FFFF;
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R11", "done held", done, 1);
        chk(fail_cnt == 9'd2, "R11", "fail_cnt held", int'(fail_cnt), 2);
        chk(err_code == 2'd0, "R11", "err_code held", int'(err_code), 0);
        launch(VECS[0]);
        chk(done == 1'b0, "R11", "done cleared by go", done, 0);
        wait_done();
        compare_run(VECS[0], "R1");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule